// File: doc/BRIEF.md
# RTC Alarm and Interrupt Flag Unit

This block holds the alarm compare registers, the control byte and the interrupt status logic of a PC-style real-time clock. A separate timekeeping counter supplies the current seconds, minutes, hours, day-of-month and month bytes. It also supplies a once-per-second update strobe and a periodic tick. On each update strobe the block compares the time against up to five alarm fields, and any field can be made to match every value.

Three sticky flags record periodic ticks, update strobes and alarm matches. Each flag sets whatever its enable bit holds. A summary bit and the interrupt request output rise only when a flag and its enable are both set. Software reaches the registers through a byte-wide address/data port. Reading the status byte hands back the flags and clears them in the same cycle, and that read is how an interrupt is acknowledged.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: After reset the control byte reads 0x02 (24-hour mode set, every interrupt enable clear), the status byte reads 0x00, `irqOut` is low and `busRdData` is 0x00.
- R2: Register addresses are 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 day alarm, 4 month alarm, 5 control, 6 status. A read returns its byte on `busRdData` one clock after `busRdEn`. Alarm bytes read back as written. Control bits 7 and 3 are not stored and read 0, so writing 0xFF reads back 0x77.
- R3: An `updTick` pulse sets the update flag, status bit 4.
- R4: A `perTick` pulse sets the periodic flag, status bit 6.
- R5: On an `updTick` pulse the alarm flag (status bit 5) sets when every alarm field that is not a wildcard equals its time field. Otherwise the alarm flag is left unchanged.
- R6: An alarm byte of 0xFF matches any value of its time field.
- R7: Only the low 6 bits of the day alarm are compared and read back. A day alarm whose low 6 bits are zero matches any day.
- R8: A month alarm of 0x00 matches any month.
- R9: Flags set even when their enables are clear. Control bit 6 enables the periodic flag, bit 5 the alarm flag and bit 4 the update flag. Status bit 7 and `irqOut` are high exactly when some flag and its enable are both set.
- R10: A status read returns every flag and the summary bit, then clears all of them, so `irqOut` drops one clock after the read.
- R11: When a flag-setting event falls in the same cycle as a status read, the read returns the flags from before that event, and the new flag stays set afterwards.
- R12: Writes to the status address or to an unmapped address change nothing. Reads of an unmapped address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address |
| busWrEn | input | 1 | Write strobe, one cycle per byte |
| busRdEn | input | 1 | Read strobe, one cycle per byte |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| timeSec | input | 8 | Current seconds |
| timeMin | input | 8 | Current minutes |
| timeHour | input | 8 | Current hours |
| timeDay | input | 8 | Current day of month |
| timeMon | input | 8 | Current month |
| updTick | input | 1 | Once-per-second update strobe |
| perTick | input | 1 | Periodic tick |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
A status read and a flag-setting tick can land on the same clock edge. Without care, that read would wipe out an event that software never saw. The bench provokes this by raising `perTick` in the very cycle it strobes a status read. It then expects the returned byte to show only the update flag that was pending beforehand. After that, it expects `irqOut` to stay high because the periodic flag survived, and a second read to return the periodic flag together with the summary bit.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  // register select, value equals the register address
  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DAY  = 3'd3,
    SEL_MON  = 3'd4,
    SEL_CTRL = 3'd5,
    SEL_STAT = 3'd6,
    SEL_NONE = 3'd7
  } regSel_e;

  // strobes from the access decoder to the datapath
  typedef struct packed {
    logic    wrSec;
    logic    wrMin;
    logic    wrHour;
    logic    wrDay;
    logic    wrMon;
    logic    wrCtrl;
    logic    rdStatus;
    logic    rdLoad;
    regSel_e rdSel;
  } regStrb_t;

  localparam int NUM_REGS = 7;

  // control byte fields
  localparam int CTRL_PIE = 6;
  localparam int CTRL_AIE = 5;
  localparam int CTRL_UIE = 4;
  localparam int CTRL_BIN = 2;
  localparam int CTRL_H24 = 1;
  localparam int CTRL_DST = 0;
  localparam logic [7:0] CTRL_WMASK = 8'h77;
  localparam logic [7:0] CTRL_RESET = 8'h02;

  // status byte fields
  localparam int STAT_IRQ = 7;
  localparam int STAT_PF  = 6;
  localparam int STAT_AF  = 5;
  localparam int STAT_UF  = 4;

  localparam logic [7:0] ALARM_ANY = 8'hFF;

endpackage

// File: rtl/rtc_alarm_ctrl.sv
module rtc_alarm_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output regStrb_t          strb
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_REGS - 1);

  regSel_e sel;

  always_comb begin
    sel = SEL_NONE;
    if (busAddr <= LAST_ADDR) sel = regSel_e'(busAddr[2:0]);
  end

  always_comb begin
    strb       = '0;
    strb.rdSel = SEL_NONE;
    if (busWrEn) begin
      case (sel)
        SEL_SEC:  strb.wrSec  = 1'b1;
        SEL_MIN:  strb.wrMin  = 1'b1;
        SEL_HOUR: strb.wrHour = 1'b1;
        SEL_DAY:  strb.wrDay  = 1'b1;
        SEL_MON:  strb.wrMon  = 1'b1;
        SEL_CTRL: strb.wrCtrl = 1'b1;
        default:  ;
      endcase
    end
    if (busRdEn) begin
      strb.rdLoad   = 1'b1;
      strb.rdSel    = sel;
      strb.rdStatus = (sel == SEL_STAT);
    end
  end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [7:0] alarmSec,
  input  logic [7:0] alarmMin,
  input  logic [7:0] alarmHour,
  input  logic [7:0] alarmDay,
  input  logic [7:0] alarmMon,
  input  logic [7:0] timeSec,
  input  logic [7:0] timeMin,
  input  logic [7:0] timeHour,
  input  logic [7:0] timeDay,
  input  logic [7:0] timeMon,
  output logic       alarmHit
);

  function automatic logic fieldHit(input logic [7:0] alm, input logic [7:0] now);
    return (alm == ALARM_ANY) || (alm == now);
  endfunction

  logic secHit, minHit, hourHit, dayHit, monHit;

  always_comb begin
    secHit  = fieldHit(alarmSec, timeSec);
    minHit  = fieldHit(alarmMin, timeMin);
    hourHit = fieldHit(alarmHour, timeHour);
    // day: six significant bits, zero means any day
    dayHit  = (alarmDay == ALARM_ANY) || (alarmDay[5:0] == 6'd0) ||
              ({2'b00, alarmDay[5:0]} == timeDay);
    // month: zero means any month
    monHit  = (alarmMon == 8'h00) || fieldHit(alarmMon, timeMon);
    alarmHit = secHit && minHit && hourHit && dayHit && monHit;
  end

endmodule

// File: rtl/rtc_alarm_dp.sv
module rtc_alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter bit HAS_DAY_ALARM = 1'b1,
  parameter bit HAS_MON_ALARM = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrb_t   strb,
  input  logic [7:0] wrData,
  input  logic       updTick,
  input  logic       perTick,
  input  logic       alarmHit,
  output logic [7:0] alarmSec,
  output logic [7:0] alarmMin,
  output logic [7:0] alarmHour,
  output logic [7:0] alarmDay,
  output logic [7:0] alarmMon,
  output logic [7:0] rdData,
  output logic       irqOut
);

  localparam bit MON_PRESENT = HAS_DAY_ALARM && HAS_MON_ALARM;

  logic [7:0] ctrlReg;
  logic       pfFlag, afFlag, ufFlag;
  logic       irqSum;
  logic [7:0] statusByte;
  logic [7:0] rdMux;

  // alarm registers, always present
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmSec  <= '0;
      alarmMin  <= '0;
      alarmHour <= '0;
    end else begin
      if (strb.wrSec)  alarmSec  <= wrData;
      if (strb.wrMin)  alarmMin  <= wrData;
      if (strb.wrHour) alarmHour <= wrData;
    end
  end

  // optional day alarm; absent means match any day
  generate
    if (HAS_DAY_ALARM) begin : gDay
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          alarmDay <= '0;
        else if (strb.wrDay) alarmDay <= wrData;
      end
    end else begin : gNoDay
      assign alarmDay = '0;
    end
  endgenerate

  // optional month alarm, only with a day alarm
  generate
    if (MON_PRESENT) begin : gMon
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          alarmMon <= '0;
        else if (strb.wrMon) alarmMon <= wrData;
      end
    end else begin : gNoMon
      assign alarmMon = '0;
    end
  endgenerate

  // control byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ctrlReg <= CTRL_RESET;
    else if (strb.wrCtrl) ctrlReg <= wrData & CTRL_WMASK;
  end

  // sticky flags: set events win over the clearing read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pfFlag <= 1'b0;
      afFlag <= 1'b0;
      ufFlag <= 1'b0;
    end else begin
      pfFlag <= (pfFlag && !strb.rdStatus) || perTick;
      ufFlag <= (ufFlag && !strb.rdStatus) || updTick;
      afFlag <= (afFlag && !strb.rdStatus) || (updTick && alarmHit);
    end
  end

  always_comb begin
    irqSum = (pfFlag && ctrlReg[CTRL_PIE]) ||
             (afFlag && ctrlReg[CTRL_AIE]) ||
             (ufFlag && ctrlReg[CTRL_UIE]);
    statusByte           = '0;
    statusByte[STAT_IRQ] = irqSum;
    statusByte[STAT_PF]  = pfFlag;
    statusByte[STAT_AF]  = afFlag;
    statusByte[STAT_UF]  = ufFlag;
  end

  assign irqOut = irqSum;

  always_comb begin
    case (strb.rdSel)
      SEL_SEC:  rdMux = alarmSec;
      SEL_MIN:  rdMux = alarmMin;
      SEL_HOUR: rdMux = alarmHour;
      SEL_DAY:  rdMux = {2'b00, alarmDay[5:0]};
      SEL_MON:  rdMux = alarmMon;
      SEL_CTRL: rdMux = ctrlReg;
      SEL_STAT: rdMux = statusByte;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= rdMux;
  end

  // R3
  upd_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    updTick |=> ufFlag);

  // R4
  per_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    perTick |=> pfFlag);

  // R5
  alarm_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updTick && alarmHit) |=> afFlag);

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdStatus && !updTick && !perTick) |=> (!irqOut && !pfFlag && !afFlag && !ufFlag));

  // R11
  read_returns_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdStatus |=> (rdData[6:4] == $past({pfFlag, afFlag, ufFlag})));

  // R9
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdStatus |=> (({pfFlag, afFlag, ufFlag} & $past({pfFlag, afFlag, ufFlag}))
                        == $past({pfFlag, afFlag, ufFlag})));

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> (ctrlReg == ($past(wrData) & CTRL_WMASK)));

endmodule

// File: rtl/rtc_alarm_irq_unit.sv
module rtc_alarm_irq_unit
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter bit HAS_DAY_ALARM = 1'b1,
  parameter bit HAS_MON_ALARM = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [7:0]        busWrData,
  output logic [7:0]        busRdData,
  input  logic [7:0]        timeSec,
  input  logic [7:0]        timeMin,
  input  logic [7:0]        timeHour,
  input  logic [7:0]        timeDay,
  input  logic [7:0]        timeMon,
  input  logic              updTick,
  input  logic              perTick,
  output logic              irqOut
);

  regStrb_t   strb;
  logic [7:0] alarmSec, alarmMin, alarmHour, alarmDay, alarmMon;
  logic       alarmHit;

  rtc_alarm_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strb    (strb)
  );

  rtc_alarm_match uMatch (
    .alarmSec  (alarmSec),
    .alarmMin  (alarmMin),
    .alarmHour (alarmHour),
    .alarmDay  (alarmDay),
    .alarmMon  (alarmMon),
    .timeSec   (timeSec),
    .timeMin   (timeMin),
    .timeHour  (timeHour),
    .timeDay   (timeDay),
    .timeMon   (timeMon),
    .alarmHit  (alarmHit)
  );

  rtc_alarm_dp #(
    .HAS_DAY_ALARM (HAS_DAY_ALARM),
    .HAS_MON_ALARM (HAS_MON_ALARM)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .updTick   (updTick),
    .perTick   (perTick),
    .alarmHit  (alarmHit),
    .alarmSec  (alarmSec),
    .alarmMin  (alarmMin),
    .alarmHour (alarmHour),
    .alarmDay  (alarmDay),
    .alarmMon  (alarmMon),
    .rdData    (busRdData),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/tb_rtc_alarm_irq_unit.sv
`timescale 1ns/1ps
module tb_rtc_alarm_irq_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic       busRdEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [7:0] timeSec = '0, timeMin = '0, timeHour = '0, timeDay = '0, timeMon = '0;
  logic       updTick = 1'b0;
  logic       perTick = 1'b0;
  logic       irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  rtc_alarm_irq_unit dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .timeSec(timeSec), .timeMin(timeMin),
    .timeHour(timeHour), .timeDay(timeDay), .timeMon(timeMon), .updTick(updTick),
    .perTick(perTick), .irqOut(irqOut)
  );

  // {alarm sec,min,hour,day,mon, time sec,min,hour,day,mon, expected alarm flag}
  localparam logic [80:0] VEC [10] = '{
    {8'h30, 8'h15, 8'h12, 8'hFF, 8'hFF, 8'h30, 8'h15, 8'h12, 8'h05, 8'h06, 1'b1},
    {8'h30, 8'h15, 8'h12, 8'hFF, 8'hFF, 8'h31, 8'h15, 8'h12, 8'h05, 8'h06, 1'b0},
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h47, 8'h02, 8'h19, 8'h28, 8'h02, 1'b1},
    {8'hFF, 8'h15, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h16, 8'h09, 8'h01, 8'h01, 1'b0},
    {8'h00, 8'h00, 8'h08, 8'hC5, 8'hFF, 8'h00, 8'h00, 8'h08, 8'h05, 8'h11, 1'b1},
    {8'h59, 8'h30, 8'h07, 8'h00, 8'h12, 8'h59, 8'h30, 8'h07, 8'h22, 8'h12, 1'b1},
    {8'h59, 8'h30, 8'h07, 8'h40, 8'h03, 8'h59, 8'h30, 8'h07, 8'h14, 8'h04, 1'b0},
    {8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 1'b1},
    {8'h00, 8'h00, 8'h00, 8'h15, 8'h01, 8'h00, 8'h00, 8'h00, 8'h16, 8'h01, 1'b0},
    {8'h10, 8'h20, 8'h05, 8'h09, 8'h00, 8'h10, 8'h20, 8'h05, 8'h09, 8'h07, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic pulse(input logic u, input logic p);
    @(negedge clk);
    updTick = u; perTick = p;
    @(negedge clk);
    updTick = 1'b0; perTick = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] rv;
    logic [80:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R1 rdData", busRdData, 8'h00);
    rdReg(4'd6, rv); chk("R1 status", rv, 8'h00);
    rdReg(4'd5, rv); chk("R1 control", rv, 8'h02);

    // R2 register readback
    wrReg(4'd5, 8'hFF); rdReg(4'd5, rv); chk("R2 control mask", rv, 8'h77);
    wrReg(4'd5, 8'h02);
    wrReg(4'd0, 8'h45); rdReg(4'd0, rv); chk("R2 sec alarm", rv, 8'h45);
    wrReg(4'd2, 8'h23); rdReg(4'd2, rv); chk("R2 hour alarm", rv, 8'h23);

    // R7 day alarm readback keeps six bits
    wrReg(4'd3, 8'hC5); rdReg(4'd3, rv); chk("R7 day readback", rv, 8'h05);

    // R12 unmapped and read-only addresses
    rdReg(4'd15, rv); chk("R12 unmapped read", rv, 8'h00);
    wrReg(4'd7, 8'hAA); rdReg(4'd7, rv); chk("R12 unmapped write", rv, 8'h00);
    wrReg(4'd6, 8'hFF); rdReg(4'd6, rv); chk("R12 status write", rv, 8'h00);
    rdReg(4'd5, rv); chk("R12 control untouched", rv, 8'h02);

    // alarm comparison table, enables clear (R5 R6 R7 R8 R9 R3)
    for (int i = 0; i < 10; i++) begin
      v = VEC[i];
      wrReg(4'd0, v[80:73]); wrReg(4'd1, v[72:65]); wrReg(4'd2, v[64:57]);
      wrReg(4'd3, v[56:49]); wrReg(4'd4, v[48:41]);
      timeSec = v[40:33]; timeMin = v[32:25]; timeHour = v[24:17];
      timeDay = v[16:9];  timeMon = v[8:1];
      rdReg(4'd6, rv);
      pulse(1'b1, 1'b0);
      chk("R9 no irq while disabled", {7'd0, irqOut}, 8'h00);
      rdReg(4'd6, rv);
      chk("R5 alarm match vector", rv, v[0] ? 8'h30 : 8'h10);
      chk("R3 update flag", rv & 8'h10, 8'h10);
    end
    timeSec = 8'h11;

    // R4 periodic flag, R10 clear on read
    pulse(1'b0, 1'b1);
    rdReg(4'd6, rv); chk("R4 periodic flag", rv, 8'h40);
    rdReg(4'd6, rv); chk("R10 cleared after read", rv, 8'h00);

    // R9 enabled update flag drives irq; R10 acknowledge
    wrReg(4'd5, 8'h12);
    pulse(1'b1, 1'b0);
    chk("R9 irq with update enable", {7'd0, irqOut}, 8'h01);
    rdReg(4'd6, rv); chk("R10 status with summary", rv, 8'h90);
    chk("R10 irq dropped", {7'd0, irqOut}, 8'h00);

    // R9 flag without its enable
    wrReg(4'd5, 8'h42);
    pulse(1'b1, 1'b0);
    chk("R9 irq masked", {7'd0, irqOut}, 8'h00);
    rdReg(4'd6, rv); chk("R9 flag set while disabled", rv, 8'h10);

    // R11 status read and periodic tick on the same edge
    pulse(1'b1, 1'b0);
    @(negedge clk);
    busAddr = 4'd6; busRdEn = 1'b1; perTick = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; perTick = 1'b0;
    chk("R11 read returns prior flags", busRdData, 8'h10);
    chk("R11 irq kept by new flag", {7'd0, irqOut}, 8'h01);
    rdReg(4'd6, rv); chk("R11 new flag survived", rv, 8'hC0);
    chk("R11 irq after second read", {7'd0, irqOut}, 8'h00);

    // R6 all-wildcard alarm with alarm enable
    wrReg(4'd5, 8'h22);
    wrReg(4'd0, 8'hFF); wrReg(4'd1, 8'hFF); wrReg(4'd2, 8'hFF);
    wrReg(4'd3, 8'hFF); wrReg(4'd4, 8'hFF);
    pulse(1'b1, 1'b0);
    chk("R6 wildcard alarm irq", {7'd0, irqOut}, 8'h01);
    rdReg(4'd6, rv); chk("R6 wildcard alarm status", rv, 8'hB0);

    finishRun();
  end

endmodule